// File: doc/BRIEF.md
# Interlocked Bus Read Handshake

This block performs single-word reads across a shared multiplexed bus between two independent state machines: a requester that owns the caller's side, and a memory responder that holds a small word array. Three control lines pace the transfer: a read request, a data-ready strobe and an acknowledge. Every edge on one of these lines waits until the opposite party's previous edge has been seen. Timing is therefore set by the interlock and not by a fixed number of clocks.

A caller pulses `rd_start` with an address while the link is idle. The requester puts the address on the bus and raises the read request. The responder captures the address and acknowledges. The requester then withdraws its request and releases the bus, and the responder drops its acknowledge. Next, the responder drives the word and raises data-ready. The requester captures the word and acknowledges. Finally the responder withdraws data-ready and releases the bus, and the requester drops its acknowledge and reports completion. Each side sees the other's control lines only through a multi-flop synchronizer. The bus and the three control lines are brought out so that the handshake can be observed.

Top module: `hsr_read_link`

## Requirements
- R1: While reset is applied and after it is released, `bus_readreq`, `bus_datardy`, `bus_ack`, `rd_busy`, `rd_done`, `rd_data` and `bus_data` are all zero. An undriven bus reads as zero.
- R2: A `rd_start` pulse seen while `rd_busy` is low raises `bus_readreq` and `rd_busy` one cycle later. The request address sits in the low AW bits of `bus_data` while the request is high.
- R3: The responder's array holds, at address a, the word (a*40503 + 4660) mod 2^DW. A completed read returns that word on `rd_data`.
- R4: The read request rises only while neither acknowledge nor data-ready is high. The responder's acknowledge falls only after the read request is low.
- R5: The two sides never drive the bus in the same cycle. While `bus_datardy` is high, `bus_data` carries the word for the requested address.
- R6: `rd_done` is a one-cycle pulse. In that cycle `rd_busy` is low and `rd_data` holds the word that was read.
- R7: A `rd_start` pulse while `rd_busy` is high is ignored. It changes neither the address in flight nor the returned word, and it produces no extra `rd_done`.
- R8: Reads can be issued back to back, each starting as soon as `rd_busy` falls. With two synchronizer stages, `rd_done` arrives 19 cycles after the start edge.
- R9: Data-ready rises only while both acknowledges and the read request are low. It falls only while the requester's acknowledge is high. The requester's acknowledge falls only after data-ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both machines |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 1 | Pulse to begin a read |
| rd_addr | input | AW | Word address, sampled with `rd_start` |
| rd_busy | output | 1 | A read is in progress |
| rd_done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Last word read |
| bus_data | output | BW | Shared bus value, where BW is the larger of AW and DW |
| bus_readreq | output | 1 | Read request line |
| bus_datardy | output | 1 | Data-ready line |
| bus_ack | output | 1 | Acknowledge line, driven by either side |

## Verification
A `rd_start` accepted on an edge shows as `bus_readreq` and `rd_busy` one cycle later. The bench checks this at the first falling edge after the start is released. Each synchronizer adds two cycles to every control edge, so a read completes 19 cycles after its start edge. The scoreboard stamps each start with the cycle count and checks the latency when `rd_done` appears, within a window around that nominal value. The bus monitor checks the address and the data word on the rising edge of the request and of data-ready. All outputs are sampled on the falling clock edge, half a cycle after they change.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_ACKLOW, RQ_WAITDATA, RQ_HOLD
  } rq_state_t;

  typedef enum logic [2:0] {
    MR_IDLE, MR_ACK, MR_FETCH, MR_DATA, MR_TAIL
  } mr_state_t;

  // Content of the responder array at a given address, full 32-bit result.
  function automatic logic [31:0] fill_word(input logic [31:0] a);
    return a * 32'd40503 + 32'd4660;
  endfunction

endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsr_requester.sv
module hsr_requester
  import hsr_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int BW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic          peer_ack,
  input  logic          peer_datardy,
  input  logic [BW-1:0] bus_in,
  output logic          readreq,
  output logic          ack,
  output logic          drive,
  output logic [BW-1:0] bus_out,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] data
);
  rq_state_t     st;
  logic [AW-1:0] addr_q;
  logic          ack_s, drdy_s;

  hsr_sync #(.STAGES(STAGES)) u_sync_ack  (.clk(clk), .rst_n(rst_n), .d(peer_ack),     .q(ack_s));
  hsr_sync #(.STAGES(STAGES)) u_sync_drdy (.clk(clk), .rst_n(rst_n), .d(peer_datardy), .q(drdy_s));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RQ_IDLE;
      addr_q  <= '0;
      readreq <= 1'b0;
      ack     <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        RQ_IDLE: if (start) begin
          addr_q  <= addr;
          readreq <= 1'b1;
          st      <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) begin
          readreq <= 1'b0;
          st      <= RQ_ACKLOW;
        end
        RQ_ACKLOW: if (!ack_s) st <= RQ_WAITDATA;
        RQ_WAITDATA: if (drdy_s) begin
          data <= bus_in[DW-1:0];
          ack  <= 1'b1;
          st   <= RQ_HOLD;
        end
        RQ_HOLD: if (!drdy_s) begin
          ack  <= 1'b0;
          done <= 1'b1;
          st   <= RQ_IDLE;
        end
        default: st <= RQ_IDLE;
      endcase
    end
  end

  assign drive   = (st == RQ_ADDR);
  assign bus_out = BW'(addr_q);
  assign busy    = (st != RQ_IDLE);
endmodule

// File: rtl/hsr_responder.sv
module hsr_responder
  import hsr_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int BW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          peer_readreq,
  input  logic          peer_ack,
  input  logic [BW-1:0] bus_in,
  output logic          ack,
  output logic          datardy,
  output logic          drive,
  output logic [BW-1:0] bus_out
);
  localparam int DEPTH = 1 << AW;

  mr_state_t     st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] word_q;
  logic [DW-1:0] mem [DEPTH];
  logic          rreq_s, ack_s;

  hsr_sync #(.STAGES(STAGES)) u_sync_req (.clk(clk), .rst_n(rst_n), .d(peer_readreq), .q(rreq_s));
  hsr_sync #(.STAGES(STAGES)) u_sync_ack (.clk(clk), .rst_n(rst_n), .d(peer_ack),     .q(ack_s));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(fill_word(32'(i)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= MR_IDLE;
      addr_q  <= '0;
      word_q  <= '0;
      ack     <= 1'b0;
      datardy <= 1'b0;
    end else begin
      case (st)
        MR_IDLE: if (rreq_s) begin
          addr_q <= bus_in[AW-1:0];
          ack    <= 1'b1;
          st     <= MR_ACK;
        end
        MR_ACK: if (!rreq_s) begin
          ack <= 1'b0;
          st  <= MR_FETCH;
        end
        MR_FETCH: begin
          word_q  <= mem[addr_q];
          datardy <= 1'b1;
          st      <= MR_DATA;
        end
        MR_DATA: if (ack_s) begin
          datardy <= 1'b0;
          st      <= MR_TAIL;
        end
        MR_TAIL: if (!ack_s) st <= MR_IDLE;
        default: st <= MR_IDLE;
      endcase
    end
  end

  assign drive   = (st == MR_DATA);
  assign bus_out = BW'(word_q);
endmodule

// File: rtl/hsr_read_link.sv
module hsr_read_link #(
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int STAGES = 2,
  localparam int BW    = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_start,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_busy,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic [BW-1:0] bus_data,
  output logic          bus_readreq,
  output logic          bus_datardy,
  output logic          bus_ack
);
  logic          req_drv, mem_drv, req_ack, mem_ack;
  logic [BW-1:0] req_bus, mem_bus;

  hsr_requester #(.AW(AW), .DW(DW), .BW(BW), .STAGES(STAGES)) u_req (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .addr(rd_addr),
    .peer_ack(mem_ack), .peer_datardy(bus_datardy), .bus_in(bus_data),
    .readreq(bus_readreq), .ack(req_ack), .drive(req_drv), .bus_out(req_bus),
    .busy(rd_busy), .done(rd_done), .data(rd_data)
  );

  hsr_responder #(.AW(AW), .DW(DW), .BW(BW), .STAGES(STAGES)) u_mem (
    .clk(clk), .rst_n(rst_n), .peer_readreq(bus_readreq), .peer_ack(req_ack),
    .bus_in(bus_data), .ack(mem_ack), .datardy(bus_datardy),
    .drive(mem_drv), .bus_out(mem_bus)
  );

  assign bus_data = req_drv ? req_bus : (mem_drv ? mem_bus : '0);
  assign bus_ack  = req_ack | mem_ack;
endmodule

// File: rtl/hsr_read_link_chk.sv
module hsr_read_link_chk (
  input logic clk,
  input logic rst_n,
  input logic readreq,
  input logic datardy,
  input logic req_ack,
  input logic mem_ack,
  input logic req_drv,
  input logic mem_drv,
  input logic rd_done,
  input logic rd_busy
);
  assert_single_driver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_drv && mem_drv));
  assert_req_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(readreq) |-> (!mem_ack && !datardy));
  assert_ack_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ack) |-> !readreq);
  assert_drdy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(datardy) |-> (!readreq && !mem_ack && !req_ack));
  assert_drdy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(datardy) |-> req_ack);
  assert_reqack_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ack) |-> !datardy);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  assert_busy_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    readreq |-> rd_busy);
endmodule

bind hsr_read_link hsr_read_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .readreq(bus_readreq), .datardy(bus_datardy),
  .req_ack(req_ack), .mem_ack(mem_ack), .req_drv(req_drv), .mem_drv(mem_drv),
  .rd_done(rd_done), .rd_busy(rd_busy)
);

// File: tb/sim_hsr_read_link.sv
module sim_hsr_read_link;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NOMINAL = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_busy, rd_done, bus_readreq, bus_datardy, bus_ack;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] bus_data;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  bit finished = 1'b0;

  logic [AW-1:0] q_addr[$];
  int            q_t0[$];

  hsr_read_link #(.AW(AW), .DW(DW), .STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_busy(rd_busy), .rd_done(rd_done), .rd_data(rd_data),
    .bus_data(bus_data), .bus_readreq(bus_readreq),
    .bus_datardy(bus_datardy), .bus_ack(bus_ack)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [DW-1:0] want(input logic [AW-1:0] a);
    int unsigned v;
    v = (int'(a) * 40503 + 4660) % 65536;
    return v[DW-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit poke);
    @(negedge clk);
    while (rd_busy) @(negedge clk);
    rd_start = 1'b1;
    rd_addr  = a;
    q_addr.push_back(a);
    q_t0.push_back(cycle + 1);
    @(negedge clk);
    rd_start = 1'b0;
    check(rd_busy && bus_readreq, "R2", "busy/readreq after start",
          {rd_busy, bus_readreq}, 2'b11);
    check(bus_data[AW-1:0] == a, "R2", "address on bus", bus_data, a);
    if (poke) begin
      repeat (5) @(negedge clk);
      rd_start = 1'b1;
      rd_addr  = ~a;
      @(negedge clk);
      rd_start = 1'b0;
    end
  endtask

  // Scoreboard monitor and bus observer
  logic prev_req = 1'b0, prev_drdy = 1'b0, prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (bus_readreq && bus_datardy)
        check(1'b0, "R4", "request and data-ready together", 1, 0);
      if (bus_datardy && !prev_drdy && q_addr.size() > 0)
        check(bus_data == want(q_addr[0]), "R5", "data word on bus",
              bus_data, want(q_addr[0]));
      if (bus_readreq && !prev_req && q_addr.size() > 0)
        check(bus_data[AW-1:0] == q_addr[0], "R7", "address held on bus",
              bus_data, q_addr[0]);
      if (prev_done && rd_done)
        check(1'b0, "R6", "done wider than one cycle", 1, 0);
      if (rd_done) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R7", "unexpected completion", 1, 0);
        end else begin
          logic [AW-1:0] a;
          int t0, lat;
          a  = q_addr.pop_front();
          t0 = q_t0.pop_front();
          lat = cycle - t0;
          check(rd_data == want(a), "R3", "returned word", rd_data, want(a));
          check(!rd_busy, "R6", "busy low with done", rd_busy, 0);
          check(lat >= NOMINAL - 4 && lat <= NOMINAL + 4, "R8",
                "completion latency", lat, NOMINAL);
        end
      end
      prev_req  <= bus_readreq;
      prev_drdy <= bus_datardy;
      prev_done <= rd_done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({bus_readreq, bus_datardy, bus_ack, rd_busy, rd_done} == 5'b0 &&
          rd_data == '0 && bus_data == '0, "R1", "outputs in reset",
          {bus_readreq, bus_datardy, bus_ack, rd_busy, rd_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({bus_readreq, bus_datardy, bus_ack, rd_busy, rd_done} == 5'b0 &&
          rd_data == '0 && bus_data == '0, "R1", "outputs after reset",
          {bus_readreq, bus_datardy, bus_ack, rd_busy, rd_done}, 0);

    do_read(4'h0, 1'b0);
    do_read(4'hF, 1'b0);
    do_read(4'h5, 1'b0);
    do_read(4'h3, 1'b1);   // R7: stray start while busy
    do_read(4'hA, 1'b0);   // R8: back to back
    do_read(4'hA, 1'b0);
    do_read(4'h6, 1'b1);
    do_read(4'h9, 1'b0);

    @(negedge clk);
    while (rd_busy) @(negedge clk);
    repeat (30) @(negedge clk);
    check(q_addr.size() == 0, "R7", "all reads completed once", q_addr.size(), 0);
    check(!rd_busy && !bus_readreq && !bus_datardy && !bus_ack, "R9",
          "lines idle after last read",
          {rd_busy, bus_readreq, bus_datardy, bus_ack}, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule